// File: doc/BRIEF.md
# Rotated-Byte Immediate Search Unit

This unit decides whether a 32-bit constant can be written as one byte rotated right by an even number of bit positions. Such a form is the twelve-bit immediate of a fixed-width instruction: an 8-bit value and a 4-bit field whose doubled value is the right-rotation amount, so the amount ranges over 0, 2, ..., 30. A code generator or instruction builder hands the constant in with a start pulse. The unit then tries one rotation field per clock cycle. When it finishes it raises a one-cycle done strobe. With that strobe it gives a valid flag and, when the constant fits, the byte and rotation field. Constants that cannot be encoded, such as 511 or 0x06010000, come back with valid low.

The unit also has a combinational expander. It turns a byte and rotation field back into the 32-bit value. One copy is driven from the registered result and gives a reconstructed constant, so the caller can confirm the encoding. A second copy has its own input pins and serves as a free-standing decoder. Splitting constants that do not fit into several instructions is not done here.

Top module: `rot_imm_finder`

## Requirements
- R1: While reset is active and after it is released, busy_o, done_o and valid_o are 0 and rot_o and byte_o are 0.
- R2: When valid_o is 1 at done, byte_o rotated right by 2*rot_o bit positions equals the constant accepted at start. For example, 256 gives byte 1 with field 12, 484 gives byte 121 with field 15, and 0x06000000 gives byte 6 with field 4.
- R3: Of all fields that encode the constant, the smallest is reported. The constant 0 gives byte 0 and field 0.
- R4: A start is accepted at a rising edge where start_i is 1 and busy_o is 0. For an encodable constant with reported field r, done_o rises exactly r+1 clock edges after the accepting edge.
- R5: For a constant that no field encodes, done_o rises 16 edges after the accepting edge, with valid_o 0 and rot_o and byte_o 0.
- R6: done_o is high for exactly one cycle. valid_o, rot_o, byte_o and recon_o hold their values until the next search completes.
- R7: A start_i pulse while busy_o is 1 is ignored. It neither changes the constant being searched nor starts a second search afterwards.
- R8: recon_o always equals byte_o rotated right by 2*rot_o. After a valid result it therefore equals the accepted constant.
- R9: dec_value_o equals dec_byte_i, zero-extended to 32 bits and rotated right by 2*dec_rot_i. It settles in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| start_i | input | 1 | Start request, taken only when idle |
| const_i | input | 32 | Constant to encode, sampled at the accepting edge |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion strobe |
| valid_o | output | 1 | Last search found an encoding |
| rot_o | output | 4 | Rotation field (right rotation of 2*field) |
| byte_o | output | 8 | 8-bit value of the encoding |
| recon_o | output | 32 | Registered result expanded back to 32 bits |
| dec_rot_i | input | 4 | Free-standing decoder rotation field |
| dec_byte_i | input | 8 | Free-standing decoder byte |
| dec_value_o | output | 32 | Free-standing decoder result |

## Verification
Some checks run on every cycle. done_o must be a single-cycle strobe, the result must stay still between completions, and busy must end in done. The number of busy cycles must match the reported field, or equal 16 on a miss. Whenever the result is valid, the reconstruction must equal the constant captured at acceptance. Other properties can only be shown by the bench scenarios. These are that the field reported is the smallest one that works, that unencodable constants are really rejected, that a start during a search is dropped, and that the free-standing decoder matches the reference for chosen inputs.

// File: rtl/rot_imm_pkg.sv
package rot_imm_pkg;
  typedef enum logic {
    SRCH_IDLE = 1'b0,
    SRCH_RUN  = 1'b1
  } srch_state_e;
endpackage

// File: rtl/rot_imm_rst_sync.sv
module rot_imm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rot_imm_probe.sv
// Tests one candidate field: rotate the constant left by 2*field and
// require everything above the low byte to be clear.
module rot_imm_probe #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic              hit_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int STEPS = 1 << ROT_W;

  logic [DATA_W-1:0] rotl_w [STEPS];
  logic [DATA_W-1:0] sel_w;

  for (genvar k = 0; k < STEPS; k++) begin : g_rot
    if (k == 0) begin : g_id
      assign rotl_w[k] = value_i;
    end else begin : g_sh
      assign rotl_w[k] = {value_i[DATA_W-1-2*k:0], value_i[DATA_W-1:DATA_W-2*k]};
    end
  end

  assign sel_w  = rotl_w[rot_i];
  assign hit_o  = ~|sel_w[DATA_W-1:BYTE_W];
  assign byte_o = sel_w[BYTE_W-1:0];
endmodule

// File: rtl/rot_imm_expand.sv
// Combinational expander: byte zero-extended, rotated right by 2*field.
module rot_imm_expand #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic [DATA_W-1:0] value_o
);
  logic [DATA_W-1:0]   ext_w;
  logic [2*DATA_W-1:0] wide_w;
  logic [ROT_W:0]      amt_w;

  assign ext_w   = {{(DATA_W-BYTE_W){1'b0}}, byte_i};
  assign amt_w   = {rot_i, 1'b0};
  assign wide_w  = {ext_w, ext_w} >> amt_w;
  assign value_o = wide_w[DATA_W-1:0];
endmodule

// File: rtl/rot_imm_seq.sv
module rot_imm_seq
  import rot_imm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] const_i,
  input  logic              hit_i,
  input  logic [BYTE_W-1:0] probe_byte_i,
  output logic [DATA_W-1:0] probe_value_o,
  output logic [ROT_W-1:0]  probe_rot_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic [ROT_W-1:0]  rot_o,
  output logic [BYTE_W-1:0] byte_o
);
  srch_state_e       state_q, state_d;
  logic [DATA_W-1:0] const_q;
  logic [ROT_W-1:0]  field_q, field_d;
  logic              done_q, valid_q;
  logic [ROT_W-1:0]  rot_q, rot_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              load_en, step_en, finish_en, field_en, last_w;

  always_comb begin
    last_w    = (field_q == {ROT_W{1'b1}});
    load_en   = (state_q == SRCH_IDLE) && start_i;
    finish_en = (state_q == SRCH_RUN) && (hit_i || last_w);
    step_en   = (state_q == SRCH_RUN) && !hit_i && !last_w;
    field_en  = load_en || step_en;
    field_d   = load_en ? '0 : field_q + 1'b1;
    rot_d     = hit_i ? field_q : '0;
    byte_d    = hit_i ? probe_byte_i : '0;
    state_d   = state_q;
    if (load_en)   state_d = SRCH_RUN;
    if (finish_en) state_d = SRCH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRCH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      const_q <= '0;
      field_q <= '0;
    end else begin
      if (load_en)  const_q <= const_i;
      if (field_en) field_q <= field_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rot_q   <= '0;
      byte_q  <= '0;
    end else if (finish_en) begin
      valid_q <= hit_i;
      rot_q   <= rot_d;
      byte_q  <= byte_d;
    end
  end

  assign probe_value_o = const_q;
  assign probe_rot_o   = field_q;
  assign busy_o        = (state_q == SRCH_RUN);
  assign done_o        = done_q;
  assign valid_o       = valid_q;
  assign rot_o         = rot_q;
  assign byte_o        = byte_q;
endmodule

// File: rtl/rot_imm_finder.sv
module rot_imm_finder #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] const_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic [$clog2(DATA_W/2)-1:0] rot_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [DATA_W-1:0] recon_o,
  input  logic [$clog2(DATA_W/2)-1:0] dec_rot_i,
  input  logic [BYTE_W-1:0] dec_byte_i,
  output logic [DATA_W-1:0] dec_value_o
);
  localparam int ROT_W = $clog2(DATA_W/2);

  logic              rst_sync_n;
  logic [DATA_W-1:0] probe_value_w;
  logic [ROT_W-1:0]  probe_rot_w;
  logic              probe_hit_w;
  logic [BYTE_W-1:0] probe_byte_w;

  rot_imm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rot_imm_probe #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ROT_W(ROT_W)) u_probe (
    .value_i(probe_value_w), .rot_i(probe_rot_w),
    .hit_o(probe_hit_w), .byte_o(probe_byte_w)
  );

  rot_imm_seq #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ROT_W(ROT_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .const_i(const_i),
    .hit_i(probe_hit_w), .probe_byte_i(probe_byte_w),
    .probe_value_o(probe_value_w), .probe_rot_o(probe_rot_w),
    .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
    .rot_o(rot_o), .byte_o(byte_o)
  );

  rot_imm_expand #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ROT_W(ROT_W)) u_recon (
    .byte_i(byte_o), .rot_i(rot_o), .value_o(recon_o)
  );

  rot_imm_expand #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ROT_W(ROT_W)) u_dec (
    .byte_i(dec_byte_i), .rot_i(dec_rot_i), .value_o(dec_value_o)
  );
endmodule

// File: rtl/rot_imm_finder_chk.sv
module rot_imm_finder_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [DATA_W-1:0] const_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              valid_o,
  input logic [ROT_W-1:0]  rot_o,
  input logic [BYTE_W-1:0] byte_o,
  input logic [DATA_W-1:0] recon_o
);
  localparam int STEPS = 1 << ROT_W;

  logic [DATA_W-1:0] cap_q;
  logic [ROT_W:0]    cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      cnt_q <= '0;
    end else if (start_i && !busy_o) begin
      cap_q <= const_i;
      cnt_q <= '0;
    end else if (busy_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(valid_o) && $stable(rot_o) && $stable(byte_o))); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R4
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o)); // R4
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q < (ROT_W+1)'(STEPS))); // R5
  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && valid_o) |-> (cnt_q == (ROT_W+1)'(rot_o) + 1'b1)); // R4
  AST_MISS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !valid_o) |-> (cnt_q == (ROT_W+1)'(STEPS) && rot_o == '0 && byte_o == '0)); // R5
  AST_RECON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && valid_o) |-> (recon_o == cap_q)); // R8
endmodule

bind rot_imm_finder rot_imm_finder_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ROT_W(ROT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .const_i(const_i),
  .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
  .rot_o(rot_o), .byte_o(byte_o), .recon_o(recon_o)
);

// File: tb/rot_imm_finder_tb_top.sv
`timescale 1ns/1ps
module rot_imm_finder_tb_top;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] const_i;
  logic        busy_o, done_o, valid_o;
  logic [3:0]  rot_o;
  logic [7:0]  byte_o;
  logic [31:0] recon_o;
  logic [3:0]  dec_rot_i;
  logic [7:0]  dec_byte_i;
  logic [31:0] dec_value_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  rot_imm_finder dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .const_i(const_i),
    .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
    .rot_o(rot_o), .byte_o(byte_o), .recon_o(recon_o),
    .dec_rot_i(dec_rot_i), .dec_byte_i(dec_byte_i), .dec_value_o(dec_value_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] ror32(input logic [31:0] v, input int s);
    if (s == 0) return v;
    return (v >> s) | (v << (32 - s));
  endfunction

  function automatic void ref_enc(input logic [31:0] x, output bit ok,
                                  output logic [3:0] r, output logic [7:0] n);
    ok = 0; r = '0; n = '0;
    for (int k = 0; k < 16; k++) begin
      if (!ok) begin
        logic [7:0] cand;
        cand = ror32(x, 32 - 2*k) & 32'hFF;
        if (ror32({24'b0, cand}, 2*k) == x) begin
          ok = 1; r = 4'(k); n = cand;
        end
      end
    end
  endfunction

  task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] x, input bit inject, input logic [31:0] other);
    bit ok; logic [3:0] er; logic [7:0] en; int lat;
    logic v_s; logic [3:0] r_s; logic [7:0] b_s;
    ref_enc(x, ok, er, en);
    @(negedge clk); start_i = 1'b1; const_i = x;
    @(posedge clk);
    @(negedge clk); start_i = 1'b0; const_i = ~x;
    lat = 0;
    while (!done_o && lat < 40) begin
      if (inject && lat == 1) begin start_i = 1'b1; const_i = other; end
      else start_i = 1'b0;
      @(posedge clk); @(negedge clk); lat++;
    end
    start_i = 1'b0;
    chk(valid_o == ok, "R2/R5 valid", 32'(valid_o), 32'(ok));
    if (ok) begin
      chk(lat == int'(er) + 1, "R4 latency", 32'(lat), 32'(int'(er) + 1));
      chk(rot_o == er && byte_o == en, "R3 smallest field", {20'b0, rot_o, byte_o}, {20'b0, er, en});
      chk(ror32({24'b0, byte_o}, 2*int'(rot_o)) == x, "R2 encoding", ror32({24'b0, byte_o}, 2*int'(rot_o)), x);
      chk(recon_o == x, "R8 recon", recon_o, x);
    end else begin
      chk(lat == 16, "R5 latency", 32'(lat), 32'd16);
      chk(rot_o == 0 && byte_o == 0, "R5 zero result", {20'b0, rot_o, byte_o}, 32'd0);
    end
    v_s = valid_o; r_s = rot_o; b_s = byte_o;
    @(posedge clk); @(negedge clk);
    chk(!done_o, "R6 single strobe", 32'(done_o), 32'd0);
    chk(valid_o == v_s && rot_o == r_s && byte_o == b_s, "R6 hold",
        {19'b0, valid_o, rot_o, byte_o}, {19'b0, v_s, r_s, b_s});
    if (inject)
      chk(!busy_o, "R7 start ignored while busy", 32'(busy_o), 32'd0);
    dec_rot_i = er; dec_byte_i = 8'($urandom);
    #1;
    chk(dec_value_o == ror32({24'b0, dec_byte_i}, 2*int'(er)), "R9 decoder",
        dec_value_o, ror32({24'b0, dec_byte_i}, 2*int'(er)));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; start_i = 1'b0; const_i = '0; dec_rot_i = '0; dec_byte_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy_o && !done_o && !valid_o && rot_o == 0 && byte_o == 0, "R1 in reset",
        {19'b0, valid_o, rot_o, byte_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!busy_o && !done_o && !valid_o && rot_o == 0 && byte_o == 0, "R1 after reset",
        {19'b0, valid_o, rot_o, byte_o}, 32'd0);

    // directed corners
    run_one(32'd256, 0, 0);
    chk(rot_o == 4'd12 && byte_o == 8'd1, "R2 256", {24'b0, rot_o, byte_o}, {24'b0, 4'd12, 8'd1});
    run_one(32'd484, 0, 0);
    chk(rot_o == 4'd15 && byte_o == 8'd121, "R2 484", {24'b0, rot_o, byte_o}, {24'b0, 4'd15, 8'd121});
    run_one(32'h0600_0000, 0, 0);
    chk(rot_o == 4'd4 && byte_o == 8'd6, "R2 0x06000000", {24'b0, rot_o, byte_o}, {24'b0, 4'd4, 8'd6});
    run_one(32'd0, 0, 0);
    chk(valid_o && rot_o == 0 && byte_o == 0, "R3 zero", {19'b0, valid_o, rot_o, byte_o}, 32'h1000);
    run_one(32'd3, 0, 0);
    run_one(32'hFF00_0000, 0, 0);
    run_one(32'h0000_03FC, 0, 0);
    run_one(32'd511, 0, 0);
    run_one(32'h0601_0000, 0, 0);
    run_one(32'd370, 0, 0);
    // start during a search
    run_one(32'd511, 1, 32'd1);
    run_one(32'd256, 1, 32'hFF);
    chk(rot_o == 4'd12 && byte_o == 8'd1, "R7 kept original", {24'b0, rot_o, byte_o}, {24'b0, 4'd12, 8'd1});

    // random: half built encodable, half raw
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x;
      if (i % 2 == 0) x = ror32({24'b0, 8'($urandom)}, 2 * int'($urandom % 16));
      else            x = $urandom;
      run_one(x, (i % 7 == 0), $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule